// File: doc/BRIEF.md
# Floating-Point Weight Guard with In-Word Check Bits

This block sits between a neural network datapath and a plain memory that holds single-precision (binary32) weights with no protection of its own. When a weight is written, the block folds a Hamming single-error-correcting code over the sign bit and the eight exponent bits into the word. The four check bits replace the four lowest mantissa bits, so the stored word is still 32 bits wide. Only the mantissa loses precision, and only slightly.

When a word is read back, the block recomputes the code and forms a 4-bit syndrome. It repairs one flipped sign or exponent bit and returns the weight with its four low bits cleared. A range filter follows the correction and can be switched on. It compares the repaired weight against a lower and an upper bound, normally the extremes of the fault-free weights, and replaces anything outside that range with +0.0. The correction handles single upsets in the sensitive fields. The filter catches large outliers left by multi-bit upsets.

The write path has one register stage. The read path has two: correction, then filtering.

Top module: `fp_weight_guard`

## Requirements
- R1: One cycle after `wr_valid_i`, `wr_valid_o` is high and `wr_word_o` holds the input weight's bits [31:4] unchanged. Bit k of [3:0] is check bit c_k. The protected data bits are d_i = weight[23+i] for i = 0..8, so d_8 is the sign. They sit at code positions 3,5,6,7,9,10,11,12,13 in order of i. Check bit c_k is the XOR of every d_i whose position has bit k set.
- R2: Two cycles after `rd_valid_i`, `rd_valid_o` pulses high for one cycle. It is low one cycle after `rd_valid_i`.
- R3: Reading an unaltered stored word returns bits [31:4] unchanged, bits [3:0] as zero, and `rd_corr_o` low.
- R4: Reading a stored word with exactly one of bits [31:23] inverted returns the original sign and exponent, with `rd_corr_o` high.
- R5: Reading a stored word with exactly one of bits [3:0] inverted returns bits [31:4] unchanged, with `rd_corr_o` high.
- R6: An inversion confined to bits [22:4] is neither detected nor repaired: the altered bits pass through and `rd_corr_o` stays low.
- R7: With `filt_en_i` low, `rd_clip_o` stays low and the repaired weight is returned as is.
- R8: With `filt_en_i` high, a repaired weight that is below `lo_bound_i` or above `hi_bound_i` is returned as 32'h0 with `rd_clip_o` high. Both bounds are inclusive. Ordering is signed-magnitude: a negative value lies below any positive value, -0 lies just below +0, and among negatives a larger magnitude lies lower.
- R9: Correction comes before filtering. A single upset that pushes a weight out of range is repaired and not clipped. A multi-bit upset that leaves an out-of-range value is clipped.
- R10: During and straight after reset, `wr_valid_o`, `rd_valid_o`, `rd_corr_o` and `rd_clip_o` are low.
- R11: Any nonzero syndrome raises `rd_corr_o`. A data bit is inverted only when the syndrome equals that bit's code position. Syndromes 1, 2, 4, 8, 14 and 15 leave the data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Weight to encode is present |
| wr_weight_i | input | 32 | Binary32 weight to store |
| wr_valid_o | output | 1 | Encoded word is present |
| wr_word_o | output | 32 | Word to write into memory |
| rd_valid_i | input | 1 | Word read from memory is present |
| rd_word_i | input | 32 | Stored word as read |
| filt_en_i | input | 1 | Enables the range filter |
| lo_bound_i | input | 32 | Lower bound, binary32, held stable |
| hi_bound_i | input | 32 | Upper bound, binary32, held stable |
| rd_valid_o | output | 1 | Repaired weight is present |
| rd_weight_o | output | 32 | Repaired, filtered weight |
| rd_corr_o | output | 1 | Nonzero syndrome seen for this word |
| rd_clip_o | output | 1 | Filter replaced this weight |

## Verification
An encoded word is due one cycle after its write strobe. A repaired weight and its two flags are due two cycles after the read strobe. The bench drives each strobe on a falling edge. It samples the write result on the next falling edge, and it samples the read result two falling edges later. At the falling edge in between, it confirms that the read valid is still low. Every sign and exponent combination is written and then read back clean, with each of the 13 single-bit faults, with a mantissa fault and with a double fault. The expected values come from a bench model built from explicit parity equations and a signed-magnitude compare.

// File: rtl/fwg_pkg.sv
package fwg_pkg;
  localparam int EXP_W  = 8;
  localparam int MAN_W  = 23;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int DATA_W = 1 + EXP_W;
  localparam int CHK_W  = 4;
  localparam int CODE_W = DATA_W + CHK_W;

  // code position of protected data bit i (skips powers of two)
  function automatic int data_pos(int i);
    int n, r;
    n = 0;
    r = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == i) r = p;
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [CHK_W-1:0] calc_chk(logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    int pos;
    c = '0;
    for (int i = 0; i < DATA_W; i++) begin
      pos = data_pos(i);
      for (int k = 0; k < CHK_W; k++)
        if (((pos >> k) & 1) == 1) c[k] = c[k] ^ d[i];
    end
    return c;
  endfunction

  // maps signed-magnitude float onto unsigned order
  function automatic logic [WORD_W-1:0] order_key(logic [WORD_W-1:0] w);
    return w[WORD_W-1] ? ~w : (w | {1'b1, {(WORD_W-1){1'b0}}});
  endfunction
endpackage

// File: rtl/fwg_encoder.sv
module fwg_encoder
  import fwg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] weight_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] word_d;

  always_comb
    word_d = {weight_i[WORD_W-1:CHK_W], calc_chk(weight_i[WORD_W-1:MAN_W])};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      word_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) word_o <= word_d;
    end
  end
endmodule

// File: rtl/fwg_decoder.sv
module fwg_decoder
  import fwg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] weight_o,
  output logic              corr_o
);
  logic [DATA_W-1:0] data, flip;
  logic [CHK_W-1:0]  syn;

  assign data = word_i[WORD_W-1:MAN_W];
  assign syn  = word_i[CHK_W-1:0] ^ calc_chk(data);

  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    assign flip[i] = (syn == CHK_W'(data_pos(i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      weight_o <= '0;
      corr_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      corr_o  <= valid_i & (|syn);
      if (valid_i)
        weight_o <= {data ^ flip, word_i[MAN_W-1:CHK_W], {CHK_W{1'b0}}};
    end
  end
endmodule

// File: rtl/fwg_filter.sv
module fwg_filter
  import fwg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] weight_i,
  input  logic              corr_i,
  input  logic              en_i,
  input  logic [WORD_W-1:0] lo_i,
  input  logic [WORD_W-1:0] hi_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] weight_o,
  output logic              corr_o,
  output logic              clip_o
);
  logic [WORD_W-1:0] key_w, key_lo, key_hi;
  logic              outlier;

  always_comb begin
    key_w   = order_key(weight_i);
    key_lo  = order_key(lo_i);
    key_hi  = order_key(hi_i);
    outlier = en_i && ((key_w < key_lo) || (key_w > key_hi));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      weight_o <= '0;
      corr_o   <= 1'b0;
      clip_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      corr_o  <= valid_i & corr_i;
      clip_o  <= valid_i & outlier;
      if (valid_i) weight_o <= outlier ? '0 : weight_i;
    end
  end
endmodule

// File: rtl/fp_weight_guard.sv
module fp_weight_guard
  import fwg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [WORD_W-1:0] wr_weight_i,
  output logic              wr_valid_o,
  output logic [WORD_W-1:0] wr_word_o,
  input  logic              rd_valid_i,
  input  logic [WORD_W-1:0] rd_word_i,
  input  logic              filt_en_i,
  input  logic [WORD_W-1:0] lo_bound_i,
  input  logic [WORD_W-1:0] hi_bound_i,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_weight_o,
  output logic              rd_corr_o,
  output logic              rd_clip_o
);
  logic              dec_valid, dec_corr;
  logic [WORD_W-1:0] dec_weight;

  fwg_encoder i_enc (
    .clk_i, .rst_ni,
    .valid_i (wr_valid_i),
    .weight_i(wr_weight_i),
    .valid_o (wr_valid_o),
    .word_o  (wr_word_o)
  );

  fwg_decoder i_dec (
    .clk_i, .rst_ni,
    .valid_i (rd_valid_i),
    .word_i  (rd_word_i),
    .valid_o (dec_valid),
    .weight_o(dec_weight),
    .corr_o  (dec_corr)
  );

  fwg_filter i_filt (
    .clk_i, .rst_ni,
    .valid_i (dec_valid),
    .weight_i(dec_weight),
    .corr_i  (dec_corr),
    .en_i    (filt_en_i),
    .lo_i    (lo_bound_i),
    .hi_i    (hi_bound_i),
    .valid_o (rd_valid_o),
    .weight_o(rd_weight_o),
    .corr_o  (rd_corr_o),
    .clip_o  (rd_clip_o)
  );
endmodule

// File: rtl/fwg_guard_chk.sv
module fwg_guard_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_valid_i,
  input logic [31:0] wr_weight_i,
  input logic        wr_valid_o,
  input logic [31:0] wr_word_o,
  input logic        rd_valid_i,
  input logic        filt_en_i,
  input logic        rd_valid_o,
  input logic [31:0] rd_weight_o,
  input logic        rd_corr_o,
  input logic        rd_clip_o
);
  // R1
  wr_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> wr_valid_o);
  // R1
  wr_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> (wr_word_o[31:4] == $past(wr_weight_i[31:4])));
  // R2
  rd_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> ##1 rd_valid_o);
  // R3
  low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_weight_o[3:0] == 4'h0));
  // R8
  clip_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clip_o |-> (rd_weight_o == 32'h0));
  // R7
  clip_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_clip_o |-> $past(filt_en_i));
  // R10
  flag_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> (!rd_corr_o && !rd_clip_o));
endmodule

bind fp_weight_guard fwg_guard_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_valid_i (wr_valid_i),
  .wr_weight_i(wr_weight_i),
  .wr_valid_o (wr_valid_o),
  .wr_word_o  (wr_word_o),
  .rd_valid_i (rd_valid_i),
  .filt_en_i  (filt_en_i),
  .rd_valid_o (rd_valid_o),
  .rd_weight_o(rd_weight_o),
  .rd_corr_o  (rd_corr_o),
  .rd_clip_o  (rd_clip_o)
);

// File: tb/test_fp_weight_guard.sv
`timescale 1ns/1ps
module test_fp_weight_guard;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0, rd_valid_i = 1'b0, filt_en_i = 1'b0;
  logic [31:0] wr_weight_i = '0, rd_word_i = '0;
  logic [31:0] lo_bound_i = 32'hC000_0000, hi_bound_i = 32'h3FC0_0000;
  logic        wr_valid_o, rd_valid_o, rd_corr_o, rd_clip_o;
  logic [31:0] wr_word_o, rd_weight_o;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #4 clk_i = ~clk_i;

  fp_weight_guard i_fp_weight_guard (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // explicit parity equations, positions 3,5,6,7,9,10,11,12,13
  function automatic logic [3:0] ref_chk(logic [8:0] d);
    return {d[4]^d[5]^d[6]^d[7]^d[8],
            d[1]^d[2]^d[3]^d[7]^d[8],
            d[0]^d[2]^d[3]^d[5]^d[6],
            d[0]^d[1]^d[3]^d[4]^d[6]^d[8]};
  endfunction

  function automatic bit ref_lt(logic [31:0] a, logic [31:0] b);
    if (a[31] != b[31]) return a[31];
    if (!a[31]) return a[30:0] < b[30:0];
    return a[30:0] > b[30:0];
  endfunction

  task automatic ref_read(input logic [31:0] word, input bit en,
                          output logic [31:0] w, output bit corr, output bit clip);
    logic [8:0] d;
    logic [3:0] s;
    d = word[31:23];
    s = word[3:0] ^ ref_chk(d);
    case (s)
      4'd3:  d[0] = ~d[0];
      4'd5:  d[1] = ~d[1];
      4'd6:  d[2] = ~d[2];
      4'd7:  d[3] = ~d[3];
      4'd9:  d[4] = ~d[4];
      4'd10: d[5] = ~d[5];
      4'd11: d[6] = ~d[6];
      4'd12: d[7] = ~d[7];
      4'd13: d[8] = ~d[8];
      default: ;
    endcase
    corr = (s != 0);
    w = {d, word[22:4], 4'h0};
    clip = en && (ref_lt(w, lo_bound_i) || ref_lt(hi_bound_i, w));
    if (clip) w = '0;
  endtask

  task automatic do_write(logic [31:0] w, output logic [31:0] word);
    @(negedge clk_i);
    wr_weight_i = w; wr_valid_i = 1'b1;
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    check("R1 valid", {31'h0, wr_valid_o}, 32'h1);
    check("R1 word", wr_word_o, {w[31:4], ref_chk(w[31:23])});
    word = wr_word_o;
  endtask

  task automatic do_read(string tag, logic [31:0] word, bit en);
    logic [31:0] ew;
    bit ec, el;
    ref_read(word, en, ew, ec, el);
    @(negedge clk_i);
    rd_word_i = word; rd_valid_i = 1'b1; filt_en_i = en;
    @(negedge clk_i);
    rd_valid_i = 1'b0;
    check("R2 early", {31'h0, rd_valid_o}, 32'h0);
    @(negedge clk_i);
    check("R2 valid", {31'h0, rd_valid_o}, 32'h1);
    check(tag, rd_weight_o, ew);
    check({tag, " corr"}, {31'h0, rd_corr_o}, {31'h0, ec});
    check(en ? "R8 clip" : "R7 clip", {31'h0, rd_clip_o}, {31'h0, el});
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, word;
    repeat (3) @(negedge clk_i);
    // R10
    check("R10 wr_valid", {31'h0, wr_valid_o}, 32'h0);
    check("R10 rd_flags", {29'h0, rd_valid_o, rd_corr_o, rd_clip_o}, 32'h0);
    rst_ni = 1'b1;
    check("R10 after", {29'h0, rd_valid_o, rd_corr_o, rd_clip_o}, 32'h0);

    for (int d = 0; d < 512; d++) begin
      logic [18:0] man;
      bit en;
      man = 19'(d * 32'h2F5A3);
      w = {d[8:0], man, d[3:0]};
      en = d[1];
      do_write(w, word);
      do_read("R3 clean", word, en);
      for (int f = 0; f < 13; f++) begin
        if (f < 9) do_read("R4 sign/exp flip", word ^ (32'h1 << (23 + f)), en);
        else       do_read("R5 check flip", word ^ (32'h1 << (f - 9)), en);
      end
      do_read("R6 mantissa flip", word ^ (32'h1 << (4 + (d % 19))), en);
      do_read("R11 double flip",
              word ^ (32'h1 << (23 + (d % 9))) ^ (32'h1 << (23 + ((d + 3) % 9))), 1'b1);
    end

    // R9: in-range 1.0, exponent MSB flip would make it huge; repaired, not clipped
    do_write(32'h3F80_0000, word);
    do_read("R9 repaired", word ^ 32'h4000_0000, 1'b1);
    check("R9 value", rd_weight_o, 32'h3F80_0000);
    // R9: two exponent flips leave outlier, clipped
    do_read("R9 double", word ^ 32'h4000_0000 ^ 32'h0080_0000, 1'b1);
    // R8 bound edges
    do_write(32'h3FC0_0000, word); do_read("R8 hi edge", word, 1'b1);
    do_write(32'h3FC0_0010, word); do_read("R8 above hi", word, 1'b1);
    check("R8 above clipped", {31'h0, rd_clip_o}, 32'h1);
    do_write(32'hC000_0000, word); do_read("R8 lo edge", word, 1'b1);
    do_write(32'hC000_0010, word); do_read("R8 below lo", word, 1'b1);
    check("R8 below clipped", {31'h0, rd_clip_o}, 32'h1);
    do_write(32'h8000_0000, word); do_read("R8 neg zero", word, 1'b1);
    do_write(32'h7F00_0000, word); do_read("R7 no filter", word, 1'b0);
    check("R7 passes", rd_weight_o, 32'h7F00_0000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule